// File: doc/BRIEF.md
# PRBS Link Self-Test Stage

This block sits on the two message paths of a chip-to-chip link and gives the link a built-in self-test. On the transmit path a pattern source can replace the outgoing traffic with a pseudo-random word stream taken from a 16-bit maximal-length shift register. On the receive path a checker can absorb the incoming stream, lock onto it by seeding its own copy of the same shift register from the first usable word, and then compare each later word with the word it predicts.

Each stage has its own enable. When a stage is disabled it is a plain valid/ready wire with no added latency, so normal traffic passes unchanged. The checker exports a lock flag, a sticky failure flag and a saturating mismatch count, all registered, for the configuration logic to read. All state uses a synchronous active-high reset.

Top module: `prbs_selftest`

## Requirements
- R1: With `gen_en`=1, `tx_out_val` is 1 and `tx_out_msg` is the source register. After reset the register holds `SEED` (default 16'hACE1). Each step maps state s to {s[14:0], s[15]^s[13]^s[12]^s[10]}, which is the polynomial x^16+x^14+x^13+x^11+1. The register never holds zero.
- R2: With `gen_en`=1 the source register steps only in a cycle where `tx_out_rdy`=1 and holds otherwise. `tx_in_rdy` is 0, so upstream traffic is held off.
- R3: With `gen_en`=0, `tx_out_val`=`tx_in_val`, `tx_out_msg`=`tx_in_msg` and `tx_in_rdy`=`tx_out_rdy` in the same cycle. The source register holds.
- R4: With `chk_en`=0, `rx_out_val`=`rx_in_val`, `rx_out_msg`=`rx_in_msg` and `rx_in_rdy`=`rx_out_rdy` in the same cycle. The mismatch count and the failure flag do not change.
- R5: With `chk_en`=1 the checker accepts every word (`rx_in_rdy`=1) and presents nothing downstream (`rx_out_val`=0). While unseeded, the first valid non-zero word seeds it: the expected next word becomes the step of that word. A valid all-zero word is ignored and leaves the checker unseeded.
- R6: Once seeded, every valid word is compared with the expected word, and the expected word then steps. A mismatch raises `chk_failed`, which stays set until reset. It also adds 1 to `chk_errs`, which saturates at 2^ERR_W-1.
- R7: `chk_locked` rises in the cycle after the `LOCK_RUN`-th consecutive matching word (default 16). A mismatch, or `chk_en`=0, clears it together with the run count.
- R8: Driving `chk_en` to 0 unseeds the checker. After it is re-enabled, the next valid non-zero word seeds it again.
- R9: Reset sets `chk_errs`=0, `chk_failed`=0 and `chk_locked`=0, unseeds the checker, and loads `SEED` into the source register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gen_en | input | 1 | 1: transmit pattern source active, 0: transmit bypass |
| chk_en | input | 1 | 1: receive checker active, 0: receive bypass |
| tx_in_val | input | 1 | Upstream transmit word valid |
| tx_in_rdy | output | 1 | Upstream transmit ready |
| tx_in_msg | input | 16 | Upstream transmit word |
| tx_out_val | output | 1 | Link-side transmit valid |
| tx_out_rdy | input | 1 | Link-side transmit ready |
| tx_out_msg | output | 16 | Link-side transmit word |
| rx_in_val | input | 1 | Link-side receive valid |
| rx_in_rdy | output | 1 | Link-side receive ready |
| rx_in_msg | input | 16 | Link-side receive word |
| rx_out_val | output | 1 | Downstream receive valid |
| rx_out_rdy | input | 1 | Downstream receive ready |
| rx_out_msg | output | 16 | Downstream receive word |
| chk_locked | output | 1 | Checker has seen LOCK_RUN consecutive matches |
| chk_failed | output | 1 | Sticky: at least one mismatch since reset |
| chk_errs | output | ERR_W | Saturating mismatch count |

## Verification
The bench builds the block with ERR_W=4, so the count saturates at 15 after a short burst of corrupted words. It keeps the default LOCK_RUN of 16 and the default seed, so the lock threshold is crossed exactly and can be compared against an unmodified sequence. The narrow counter brings saturation, and the sticky flag staying set after the link relocks, within a run of a few hundred cycles. Zero-word seeding, a mid-stream error, and reseeding after a bypass interval are each placed where a wrong implementation would show up as a mismatch or a missed lock.

// File: rtl/prbs_pkg.sv
package prbs_pkg;
  localparam int unsigned LFSR_W = 16;
  localparam logic [LFSR_W-1:0] DEF_TAPS = 16'hB400;

  function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s,
                                                  input logic [LFSR_W-1:0] taps);
    return {s[LFSR_W-2:0], ^(s & taps)};
  endfunction
endpackage

// File: rtl/prbs_gen.sv
module prbs_gen
  import prbs_pkg::*;
#(
  parameter logic [LFSR_W-1:0] TAPS = DEF_TAPS,
  parameter logic [LFSR_W-1:0] SEED = 16'hACE1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              in_val,
  output logic              in_rdy,
  input  logic [LFSR_W-1:0] in_msg,
  output logic              out_val,
  input  logic              out_rdy,
  output logic [LFSR_W-1:0] out_msg
);
  logic [LFSR_W-1:0] state_q;
  logic              advance;

  assign advance = en && out_rdy;

  always_ff @(posedge clk) begin
    if (rst) state_q <= SEED;
    else if (advance) state_q <= lfsr_step(state_q, TAPS);
  end

  always_comb begin
    if (en) begin
      out_val = 1'b1;
      out_msg = state_q;
      in_rdy  = 1'b0;
    end else begin
      out_val = in_val;
      out_msg = in_msg;
      in_rdy  = out_rdy;
    end
  end

  // R1
  gen_nonzero_chk: assert property (@(posedge clk) disable iff (rst) state_q != '0);
  // R2
  gen_hold_chk: assert property (@(posedge clk) disable iff (rst) !advance |=> $stable(state_q));
endmodule

// File: rtl/prbs_chk.sv
module prbs_chk
  import prbs_pkg::*;
#(
  parameter logic [LFSR_W-1:0] TAPS = DEF_TAPS,
  parameter int unsigned ERR_W = 8,
  parameter int unsigned LOCK_RUN = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              in_val,
  output logic              in_rdy,
  input  logic [LFSR_W-1:0] in_msg,
  output logic              out_val,
  input  logic              out_rdy,
  output logic [LFSR_W-1:0] out_msg,
  output logic              locked,
  output logic              failed,
  output logic [ERR_W-1:0]  err_cnt
);
  localparam int unsigned RUN_W = $clog2(LOCK_RUN + 1);
  localparam logic [ERR_W-1:0] ERR_MAX = '1;
  localparam logic [RUN_W-1:0] RUN_TOP = RUN_W'(LOCK_RUN);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(LOCK_RUN - 1);

  logic              seeded_q;
  logic [LFSR_W-1:0] expect_q;
  logic [RUN_W-1:0]  run_q;
  logic              take;

  assign take = en && in_val;

  always_comb begin
    if (en) begin
      in_rdy  = 1'b1;
      out_val = 1'b0;
      out_msg = '0;
    end else begin
      in_rdy  = out_rdy;
      out_val = in_val;
      out_msg = in_msg;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seeded_q <= 1'b0;
      expect_q <= '0;
      run_q    <= '0;
      locked   <= 1'b0;
      failed   <= 1'b0;
      err_cnt  <= '0;
    end else if (!en) begin
      seeded_q <= 1'b0;
      run_q    <= '0;
      locked   <= 1'b0;
    end else if (take) begin
      if (!seeded_q) begin
        if (in_msg != '0) begin
          expect_q <= lfsr_step(in_msg, TAPS);
          seeded_q <= 1'b1;
        end
      end else begin
        expect_q <= lfsr_step(expect_q, TAPS);
        if (in_msg == expect_q) begin
          if (run_q != RUN_TOP) run_q <= run_q + 1'b1;
          if (run_q == RUN_LAST) locked <= 1'b1;
        end else begin
          run_q  <= '0;
          locked <= 1'b0;
          failed <= 1'b1;
          if (err_cnt != ERR_MAX) err_cnt <= err_cnt + 1'b1;
        end
      end
    end
  end

  // R6
  fail_sticky_chk: assert property (@(posedge clk) disable iff (rst) failed |=> failed);
  // R6
  err_mono_chk: assert property (@(posedge clk) disable iff (rst) 1'b1 |=> err_cnt >= $past(err_cnt));
  // R7
  lock_seeded_chk: assert property (@(posedge clk) disable iff (rst) locked |-> seeded_q);
  // R7
  lock_rise_chk: assert property (@(posedge clk) disable iff (rst) $rose(locked) |-> $past(take));
endmodule

// File: rtl/prbs_selftest.sv
module prbs_selftest
  import prbs_pkg::*;
#(
  parameter logic [LFSR_W-1:0] TAPS = DEF_TAPS,
  parameter logic [LFSR_W-1:0] SEED = 16'hACE1,
  parameter int unsigned ERR_W = 8,
  parameter int unsigned LOCK_RUN = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              gen_en,
  input  logic              chk_en,
  input  logic              tx_in_val,
  output logic              tx_in_rdy,
  input  logic [LFSR_W-1:0] tx_in_msg,
  output logic              tx_out_val,
  input  logic              tx_out_rdy,
  output logic [LFSR_W-1:0] tx_out_msg,
  input  logic              rx_in_val,
  output logic              rx_in_rdy,
  input  logic [LFSR_W-1:0] rx_in_msg,
  output logic              rx_out_val,
  input  logic              rx_out_rdy,
  output logic [LFSR_W-1:0] rx_out_msg,
  output logic              chk_locked,
  output logic              chk_failed,
  output logic [ERR_W-1:0]  chk_errs
);
  prbs_gen #(.TAPS(TAPS), .SEED(SEED)) u_gen (
    .clk(clk), .rst(rst), .en(gen_en),
    .in_val(tx_in_val), .in_rdy(tx_in_rdy), .in_msg(tx_in_msg),
    .out_val(tx_out_val), .out_rdy(tx_out_rdy), .out_msg(tx_out_msg)
  );

  prbs_chk #(.TAPS(TAPS), .ERR_W(ERR_W), .LOCK_RUN(LOCK_RUN)) u_chk (
    .clk(clk), .rst(rst), .en(chk_en),
    .in_val(rx_in_val), .in_rdy(rx_in_rdy), .in_msg(rx_in_msg),
    .out_val(rx_out_val), .out_rdy(rx_out_rdy), .out_msg(rx_out_msg),
    .locked(chk_locked), .failed(chk_failed), .err_cnt(chk_errs)
  );
endmodule

// File: tb/sim_prbs_selftest.sv
`timescale 1ns/1ps
module sim_prbs_selftest;
  localparam int ERR_W = 4;
  localparam int LOCK = 16;
  localparam logic [15:0] SEED = 16'hACE1;

  logic clk = 1'b0, rst = 1'b1, gen_en = 1'b0, chk_en = 1'b0;
  logic tx_in_val = 1'b0, tx_out_rdy = 1'b0, rx_in_val = 1'b0, rx_out_rdy = 1'b0;
  logic [15:0] tx_in_msg = '0, rx_in_msg = '0;
  logic tx_in_rdy, tx_out_val, rx_in_rdy, rx_out_val;
  logic [15:0] tx_out_msg, rx_out_msg;
  logic chk_locked, chk_failed;
  logic [ERR_W-1:0] chk_errs;

  int total = 0, bad = 0;
  bit finished = 0;

  logic [15:0] m_gen, m_exp;
  bit m_seeded, m_locked, m_fail;
  int m_run, m_err;
  logic [15:0] src;

  always #2.5 clk = ~clk;

  prbs_selftest #(.ERR_W(ERR_W), .LOCK_RUN(LOCK), .SEED(SEED)) u0 (
    .clk(clk), .rst(rst), .gen_en(gen_en), .chk_en(chk_en),
    .tx_in_val(tx_in_val), .tx_in_rdy(tx_in_rdy), .tx_in_msg(tx_in_msg),
    .tx_out_val(tx_out_val), .tx_out_rdy(tx_out_rdy), .tx_out_msg(tx_out_msg),
    .rx_in_val(rx_in_val), .rx_in_rdy(rx_in_rdy), .rx_in_msg(rx_in_msg),
    .rx_out_val(rx_out_val), .rx_out_rdy(rx_out_rdy), .rx_out_msg(rx_out_msg),
    .chk_locked(chk_locked), .chk_failed(chk_failed), .chk_errs(chk_errs)
  );

  function automatic logic [15:0] nxt(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    string st = rst ? "R9 " : "";
    chk({st, gen_en ? "R1 tx_out_val" : "R3 tx_out_val"}, 32'(tx_out_val), gen_en ? 32'd1 : 32'(tx_in_val));
    chk({st, gen_en ? "R1 tx_out_msg" : "R3 tx_out_msg"}, 32'(tx_out_msg), gen_en ? 32'(m_gen) : 32'(tx_in_msg));
    chk({st, gen_en ? "R2 tx_in_rdy" : "R3 tx_in_rdy"}, 32'(tx_in_rdy), gen_en ? 32'd0 : 32'(tx_out_rdy));
    chk({st, chk_en ? "R5 rx_in_rdy" : "R4 rx_in_rdy"}, 32'(rx_in_rdy), chk_en ? 32'd1 : 32'(rx_out_rdy));
    chk({st, chk_en ? "R5 rx_out_val" : "R4 rx_out_val"}, 32'(rx_out_val), chk_en ? 32'd0 : 32'(rx_in_val));
    if (!chk_en) chk({st, "R4 rx_out_msg"}, 32'(rx_out_msg), 32'(rx_in_msg));
    chk({st, "R7 chk_locked"}, 32'(chk_locked), 32'(m_locked));
    chk({st, "R6 chk_failed"}, 32'(chk_failed), 32'(m_fail));
    chk({st, "R6 chk_errs"}, 32'(chk_errs), 32'(m_err));
  endtask

  task automatic update();
    if (rst) begin
      m_gen = SEED; m_seeded = 0; m_locked = 0; m_fail = 0; m_run = 0; m_err = 0; m_exp = '0;
      return;
    end
    if (gen_en && tx_out_rdy) m_gen = nxt(m_gen);
    if (!chk_en) begin
      m_seeded = 0; m_run = 0; m_locked = 0;
    end else if (rx_in_val) begin
      if (!m_seeded) begin
        if (rx_in_msg != 0) begin m_exp = nxt(rx_in_msg); m_seeded = 1; end
      end else begin
        if (rx_in_msg == m_exp) begin
          m_run++;
          if (m_run >= LOCK) m_locked = 1;
        end else begin
          m_run = 0; m_locked = 0; m_fail = 1;
          if (m_err < (1 << ERR_W) - 1) m_err++;
        end
        m_exp = nxt(m_exp);
      end
    end
  endtask

  task automatic cyc();
    #1; compare();
    @(posedge clk); update();
    @(negedge clk);
  endtask

  // send one receive word; v=0 leaves a gap
  task automatic rx_send(input logic [15:0] w, input bit v);
    rx_in_val = v; rx_in_msg = w; cyc();
  endtask

  // send the next word of the bench stream, optionally corrupted (R6)
  task automatic rx_stream(input bit corrupt);
    rx_send(corrupt ? (src ^ 16'h0100) : src, 1'b1);
    src = nxt(src);
  endtask

  initial begin
    rst = 1'b1;
    @(posedge clk); update(); @(negedge clk);
    cyc(); cyc();                                     // R9 during reset
    rst = 1'b0; cyc();                                // R9 reset state visible

    // R1 R2: pattern source with irregular ready
    gen_en = 1'b1; tx_in_val = 1'b1; tx_in_msg = 16'h5555;
    for (int i = 0; i < 40; i++) begin tx_out_rdy = ((i % 3) != 1); cyc(); end
    tx_out_rdy = 1'b0; cyc(); cyc();                  // R2 hold

    // R3: transmit bypass
    gen_en = 1'b0;
    for (int i = 0; i < 12; i++) begin
      tx_in_val = 1'(i % 2); tx_out_rdy = 1'(i % 3 == 0); tx_in_msg = 16'($urandom); cyc();
    end
    gen_en = 1'b1; tx_out_rdy = 1'b1; cyc(); cyc();   // R3 state held across bypass

    // R5: zero word ignored, then seed
    chk_en = 1'b1;
    rx_send(16'h0000, 1'b1);
    src = 16'h1234;
    rx_stream(1'b0);
    // R7: lock after LOCK matching words, with gaps
    for (int i = 0; i < LOCK + 2; i++) begin
      if (i % 5 == 2) rx_send(16'hFFFF, 1'b0);
      rx_stream(1'b0);
    end
    chk("R7 locked after run", 32'(chk_locked), 32'd1);

    // R6: single error, then relock; sticky flag stays
    rx_stream(1'b1);
    chk("R6 failed set", 32'(chk_failed), 32'd1);
    for (int i = 0; i < LOCK; i++) rx_stream(1'b0);
    chk("R7 relocked", 32'(chk_locked), 32'd1);
    chk("R6 failed sticky", 32'(chk_failed), 32'd1);

    // R6: saturation
    for (int i = 0; i < 20; i++) rx_stream(1'b1);
    chk("R6 saturated", 32'(chk_errs), 32'((1 << ERR_W) - 1));

    // R4: receive bypass
    chk_en = 1'b0;
    for (int i = 0; i < 12; i++) begin
      rx_out_rdy = 1'(i % 2); rx_send(16'($urandom), 1'(i % 3 != 0));
    end

    // R8: reseed after re-enable
    chk_en = 1'b1;
    src = 16'hBEEF;
    for (int i = 0; i < LOCK + 3; i++) rx_stream(1'b0);
    chk("R8 reseeded lock", 32'(chk_locked), 32'd1);
    rx_in_val = 1'b0; chk_en = 1'b0; cyc();
    chk("R7 cleared by disable", 32'(chk_locked), 32'd0);

    // R9: reset clears sticky state
    rst = 1'b1; cyc(); rst = 1'b0; cyc();
    chk("R9 failed cleared", 32'(chk_failed), 32'd0);
    chk("R9 errs cleared", 32'(chk_errs), 32'd0);

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule